// File: doc/BRIEF.md
# Branch Target Buffer with Target-Miss Promotion

This block is a set-associative branch target buffer for an instruction fetch front end. Each entry holds a tag, a branch-kind code, a predicted target and a saturating count of how often that branch resolved to a target other than the stored one. A combinational lookup port answers the fetch stage in the same cycle with hit, target and kind. A resolve port, driven once per cycle by the back end, allocates, refreshes and counts entries.

When an entry's target-miss count reaches the configured threshold, the block evicts the entry and presents its tag, set and latest target on a one-cycle promotion strobe. A small side buffer outside this block then owns that branch. The side buffer steers both ports through an override path that names an explicit set and way. Branches it holds are never placed through the normal allocation path, so a branch is never in the main array and the side buffer at once.

Top module: `btb_promote`

## Requirements
- R1: After reset every entry is invalid: every lookup misses and `promo_valid` is low.
- R2: A lookup with no override uses PC bits [IDX_W+1:2] as the set index and the bits above as the tag. A hit returns the stored target and kind in the same cycle. A miss drives hit, target and kind to zero.
- R3: `lk_force_taken` is high exactly when the lookup hits an entry whose kind code is 2 (indirect). Kind codes are 0 conditional, 1 direct, 2 indirect and 3 return.
- R4: A taken resolve with no override that misses in its set writes the least recently used way. The entry gets the tag, target and kind, and its count is cleared. A lookup sees the entry from the next cycle.
- R5: Each set keeps a full recency order. A resolve hit and an allocation each make the way involved the most recent. After reset the order runs from way 0 (most recent) to the highest way (least recent).
- R6: A taken resolve that hits with a different target replaces the stored target and adds one to the count, while the count stays below MISS_THRESH. A not-taken resolve or a matching target leaves the target and count unchanged.
- R7: When a mismatch brings the count to MISS_THRESH, the entry is invalidated and its count cleared. In the cycle after that edge, `promo_valid` is high for one cycle with the entry's tag and set and the resolved target.
- R8: A lookup with `lk_ovr_valid` reads the given set and way directly. Hit equals that entry's valid bit, and target and kind come from it.
- R9: A taken resolve with `upd_ovr_valid` writes the given set and way with the PC's tag, the target and the kind, and clears the count. It allocates nothing in the PC's own set, changes no recency order and never causes a promotion.
- R10: A not-taken resolve that misses allocates nothing.
- R11: Lookups do not change any entry or any recency order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_ovr_valid | input | 1 | Read the set and way below instead of searching |
| lk_ovr_set | input | IDX_W | Override set for lookup |
| lk_ovr_way | input | WAY_W | Override way for lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_target | output | PC_W | Predicted target (zero on miss) |
| lk_kind | output | 2 | Branch kind of the hit entry (zero on miss) |
| lk_force_taken | output | 1 | Hit on an indirect entry: predict taken |
| upd_valid | input | 1 | Resolve record present this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_target | input | PC_W | Actual target |
| upd_taken | input | 1 | Branch was taken |
| upd_kind | input | 2 | Branch kind code |
| upd_ovr_valid | input | 1 | Write the set and way below instead of normal placement |
| upd_ovr_set | input | IDX_W | Override set for resolve |
| upd_ovr_way | input | WAY_W | Override way for resolve |
| promo_valid | output | 1 | One-cycle promotion strobe |
| promo_tag | output | TAG_W | Tag of the promoted branch |
| promo_set | output | IDX_W | Set the promoted branch occupied |
| promo_target | output | PC_W | Last resolved target of the promoted branch |

## Verification
The hardest state to reach from the ports is the promotion itself. The same entry must take a long run of target mismatches without being evicted by competing allocations in its set. The bench lowers the threshold to 16, sends an indirect branch alternating between two targets into a set that no other traffic touches, and checks the count-driven target replacement along the way. It then routes the promoted PC through the override path and confirms that its home set no longer holds it. A long random phase then mixes conflicting PCs over a few sets and sends promoted PCs through override placement. Each cycle is compared against a behavioural move-to-front model.

// File: rtl/btbp_pkg.sv
package btbp_pkg;

    // branch kind codes carried in each entry
    typedef enum logic [1:0] {
        KIND_COND     = 2'd0,
        KIND_DIRECT   = 2'd1,
        KIND_INDIRECT = 2'd2,
        KIND_RETURN   = 2'd3
    } br_kind_e;

endpackage

// File: rtl/btbp_match.sv
// Tag compare across the ways of one set; the lowest matching way wins.
module btbp_match #(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 21,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0]            valid,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]               key,
    output logic                           hit,
    output logic [WAY_W-1:0]               way
);

    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (valid[w] && tags[w] == key) begin
                hit = 1'b1;
                way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/btbp_lru.sv
// Per-set age ordering: age 0 is most recent, NUM_WAYS-1 is the victim.
module btbp_lru #(
    parameter int NUM_SETS = 512,
    parameter int NUM_WAYS = 4,
    localparam int IDX_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way
);

    logic [WAY_W-1:0] age_q [NUM_SETS][NUM_WAYS];
    logic [NUM_WAYS-1:0][WAY_W-1:0] row_d;
    logic [WAY_W-1:0] ref_age;

    always_comb begin
        victim = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (age_q[rd_set][w] == WAY_W'(NUM_WAYS - 1)) begin
                victim = WAY_W'(w);
            end
        end

        ref_age = age_q[touch_set][touch_way];
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (WAY_W'(w) == touch_way) begin
                row_d[w] = '0;
            end else if (age_q[touch_set][w] < ref_age) begin
                row_d[w] = age_q[touch_set][w] + 1'b1;
            end else begin
                row_d[w] = age_q[touch_set][w];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                age_q[touch_set][w] <= row_d[w];
            end
        end
    end

endmodule

// File: rtl/btbp_store.sv
// Entry array with two read ports (lookup, resolve) and one write port.
module btbp_store #(
    parameter int NUM_SETS = 512,
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 21,
    parameter int PC_W     = 32,
    parameter int CNT_W    = 10,
    localparam int IDX_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [IDX_W-1:0]               ra_set,
    output logic [NUM_WAYS-1:0]            ra_valid,
    output logic [NUM_WAYS-1:0][TAG_W-1:0] ra_tag,
    output logic [NUM_WAYS-1:0][PC_W-1:0]  ra_tgt,
    output logic [NUM_WAYS-1:0][1:0]       ra_kind,
    input  logic [IDX_W-1:0]               rb_set,
    output logic [NUM_WAYS-1:0]            rb_valid,
    output logic [NUM_WAYS-1:0][TAG_W-1:0] rb_tag,
    output logic [NUM_WAYS-1:0][PC_W-1:0]  rb_tgt,
    output logic [NUM_WAYS-1:0][1:0]       rb_kind,
    output logic [NUM_WAYS-1:0][CNT_W-1:0] rb_cnt,
    input  logic                           we,
    input  logic [IDX_W-1:0]               w_set,
    input  logic [WAY_W-1:0]               w_way,
    input  logic                           w_valid,
    input  logic [TAG_W-1:0]               w_tag,
    input  logic [PC_W-1:0]                w_tgt,
    input  logic [1:0]                     w_kind,
    input  logic [CNT_W-1:0]               w_cnt
);

    logic             valid_q [NUM_SETS][NUM_WAYS];
    logic [TAG_W-1:0] tag_q   [NUM_SETS][NUM_WAYS];
    logic [PC_W-1:0]  tgt_q   [NUM_SETS][NUM_WAYS];
    logic [1:0]       kind_q  [NUM_SETS][NUM_WAYS];
    logic [CNT_W-1:0] cnt_q   [NUM_SETS][NUM_WAYS];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
        assign ra_valid[w] = valid_q[ra_set][w];
        assign ra_tag[w]   = tag_q[ra_set][w];
        assign ra_tgt[w]   = tgt_q[ra_set][w];
        assign ra_kind[w]  = kind_q[ra_set][w];
        assign rb_valid[w] = valid_q[rb_set][w];
        assign rb_tag[w]   = tag_q[rb_set][w];
        assign rb_tgt[w]   = tgt_q[rb_set][w];
        assign rb_kind[w]  = kind_q[rb_set][w];
        assign rb_cnt[w]   = cnt_q[rb_set][w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                end
            end
        end else if (we) begin
            valid_q[w_set][w_way] <= w_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[w_set][w_way]  <= w_tag;
            tgt_q[w_set][w_way]  <= w_tgt;
            kind_q[w_set][w_way] <= w_kind;
            cnt_q[w_set][w_way]  <= w_cnt;
        end
    end

endmodule

// File: rtl/btb_promote.sv
module btb_promote #(
    parameter int NUM_SETS    = 512,
    parameter int NUM_WAYS    = 4,
    parameter int PC_W        = 32,
    parameter int MISS_THRESH = 512,
    localparam int IDX_W      = $clog2(NUM_SETS),
    localparam int WAY_W      = $clog2(NUM_WAYS),
    localparam int TAG_W      = PC_W - IDX_W - 2,
    localparam int CNT_W      = $clog2(MISS_THRESH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic             lk_ovr_valid,
    input  logic [IDX_W-1:0] lk_ovr_set,
    input  logic [WAY_W-1:0] lk_ovr_way,
    output logic             lk_hit,
    output logic [PC_W-1:0]  lk_target,
    output logic [1:0]       lk_kind,
    output logic             lk_force_taken,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic [PC_W-1:0]  upd_target,
    input  logic             upd_taken,
    input  logic [1:0]       upd_kind,
    input  logic             upd_ovr_valid,
    input  logic [IDX_W-1:0] upd_ovr_set,
    input  logic [WAY_W-1:0] upd_ovr_way,
    output logic             promo_valid,
    output logic [TAG_W-1:0] promo_tag,
    output logic [IDX_W-1:0] promo_set,
    output logic [PC_W-1:0]  promo_target
);
    import btbp_pkg::*;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] set;
        logic [PC_W-1:0]  tgt;
    } promo_t;

    promo_t st_d, st_q;

    // lookup side
    logic [IDX_W-1:0]               lk_set;
    logic [TAG_W-1:0]               lk_tag;
    logic [NUM_WAYS-1:0]            ra_valid;
    logic [NUM_WAYS-1:0][TAG_W-1:0] ra_tag;
    logic [NUM_WAYS-1:0][PC_W-1:0]  ra_tgt;
    logic [NUM_WAYS-1:0][1:0]       ra_kind;
    logic                           a_hit;
    logic [WAY_W-1:0]               a_way;
    logic [WAY_W-1:0]               lk_sel;
    logic                           lk_hit_w;

    // resolve side
    logic [IDX_W-1:0]               u_set;
    logic [TAG_W-1:0]               u_tag;
    logic [NUM_WAYS-1:0]            rb_valid;
    logic [NUM_WAYS-1:0][TAG_W-1:0] rb_tag;
    logic [NUM_WAYS-1:0][PC_W-1:0]  rb_tgt;
    logic [NUM_WAYS-1:0][1:0]       rb_kind;
    logic [NUM_WAYS-1:0][CNT_W-1:0] rb_cnt;
    logic                           b_hit;
    logic [WAY_W-1:0]               b_way;
    logic [WAY_W-1:0]               victim;
    logic [CNT_W-1:0]               cnt_inc;

    // write and recency controls
    logic             we;
    logic [IDX_W-1:0] w_set;
    logic [WAY_W-1:0] w_way;
    logic             w_valid;
    logic [PC_W-1:0]  w_tgt;
    logic [1:0]       w_kind;
    logic [CNT_W-1:0] w_cnt;
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;

    assign lk_set = lk_ovr_valid ? lk_ovr_set : lk_pc[IDX_W+1:2];
    assign lk_tag = lk_pc[PC_W-1:IDX_W+2];
    assign u_set  = upd_pc[IDX_W+1:2];
    assign u_tag  = upd_pc[PC_W-1:IDX_W+2];

    btbp_store #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W),
        .PC_W     (PC_W),
        .CNT_W    (CNT_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_set   (lk_set),
        .ra_valid (ra_valid),
        .ra_tag   (ra_tag),
        .ra_tgt   (ra_tgt),
        .ra_kind  (ra_kind),
        .rb_set   (u_set),
        .rb_valid (rb_valid),
        .rb_tag   (rb_tag),
        .rb_tgt   (rb_tgt),
        .rb_kind  (rb_kind),
        .rb_cnt   (rb_cnt),
        .we       (we),
        .w_set    (w_set),
        .w_way    (w_way),
        .w_valid  (w_valid),
        .w_tag    (u_tag),
        .w_tgt    (w_tgt),
        .w_kind   (w_kind),
        .w_cnt    (w_cnt)
    );

    btbp_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) match_lk_i (
        .valid (ra_valid),
        .tags  (ra_tag),
        .key   (lk_tag),
        .hit   (a_hit),
        .way   (a_way)
    );

    btbp_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) match_up_i (
        .valid (rb_valid),
        .tags  (rb_tag),
        .key   (u_tag),
        .hit   (b_hit),
        .way   (b_way)
    );

    btbp_lru #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) lru_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (u_set),
        .victim    (victim),
        .touch_en  (touch_en),
        .touch_set (u_set),
        .touch_way (touch_way)
    );

    // lookup: search or direct read, combinational
    always_comb begin
        lk_sel   = lk_ovr_valid ? lk_ovr_way : a_way;
        lk_hit_w = lk_ovr_valid ? ra_valid[lk_ovr_way] : a_hit;
        lk_hit         = lk_hit_w;
        lk_target      = lk_hit_w ? ra_tgt[lk_sel] : '0;
        lk_kind        = lk_hit_w ? ra_kind[lk_sel] : 2'd0;
        lk_force_taken = lk_hit_w && (ra_kind[lk_sel] == KIND_INDIRECT);
    end

    // resolve: placement, target replacement, miss counting, promotion
    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        we         = 1'b0;
        w_set      = u_set;
        w_way      = b_way;
        w_valid    = 1'b1;
        w_tgt      = upd_target;
        w_kind     = upd_kind;
        w_cnt      = '0;
        touch_en   = 1'b0;
        touch_way  = b_way;
        cnt_inc    = rb_cnt[b_way] + 1'b1;

        if (upd_valid) begin
            if (upd_ovr_valid) begin
                if (upd_taken) begin
                    we    = 1'b1;
                    w_set = upd_ovr_set;
                    w_way = upd_ovr_way;
                end
            end else if (b_hit) begin
                touch_en = 1'b1;
                if (upd_taken && rb_tgt[b_way] != upd_target) begin
                    we     = 1'b1;
                    w_kind = rb_kind[b_way];
                    if (cnt_inc == CNT_W'(MISS_THRESH)) begin
                        w_valid    = 1'b0;
                        w_cnt      = '0;
                        st_d.valid = 1'b1;
                        st_d.tag   = u_tag;
                        st_d.set   = u_set;
                        st_d.tgt   = upd_target;
                    end else begin
                        w_cnt = cnt_inc;
                    end
                end
            end else if (upd_taken) begin
                we        = 1'b1;
                w_way     = victim;
                touch_en  = 1'b1;
                touch_way = victim;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign promo_valid  = st_q.valid;
    assign promo_tag    = st_q.tag;
    assign promo_set    = st_q.set;
    assign promo_target = st_q.tgt;

endmodule

// File: rtl/btb_promote_chk.sv
module btb_promote_chk #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 9,
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  lk_pc,
    input logic             lk_ovr_valid,
    input logic             lk_hit,
    input logic [PC_W-1:0]  lk_target,
    input logic [1:0]       lk_kind,
    input logic             lk_force_taken,
    input logic             upd_valid,
    input logic             upd_taken,
    input logic             upd_ovr_valid,
    input logic             promo_valid
);

    // R3
    force_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_force_taken |-> lk_hit);

    // R3
    indirect_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_kind == 2'd2) |-> lk_force_taken);

    // R2
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_target == '0 && lk_kind == 2'd0));

    // R7
    promo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        promo_valid |-> $past(upd_valid && upd_taken && !upd_ovr_valid));

    // R9
    ovr_no_promo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_ovr_valid) |=> !promo_valid);

    // R11
    lookup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(upd_valid) && $stable(lk_pc) && !lk_ovr_valid && !$past(lk_ovr_valid))
        |-> ($stable(lk_hit) && $stable(lk_target)));

endmodule

bind btb_promote btb_promote_chk #(
    .PC_W  (PC_W),
    .IDX_W (IDX_W),
    .WAY_W (WAY_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_pc          (lk_pc),
    .lk_ovr_valid   (lk_ovr_valid),
    .lk_hit         (lk_hit),
    .lk_target      (lk_target),
    .lk_kind        (lk_kind),
    .lk_force_taken (lk_force_taken),
    .upd_valid      (upd_valid),
    .upd_taken      (upd_taken),
    .upd_ovr_valid  (upd_ovr_valid),
    .promo_valid    (promo_valid)
);

// File: tb/btb_promote_tb_top.sv
module btb_promote_tb_top;

    localparam int NS  = 16;
    localparam int NW  = 4;
    localparam int PCW = 32;
    localparam int TH  = 16;
    localparam int IW  = 4;
    localparam int WW  = 2;
    localparam int TW  = PCW - IW - 2;
    localparam int NPOOL = 12;
    localparam int OVR_SET = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [PCW-1:0] lk_pc = '0;
    logic           lk_ovr_valid = 1'b0;
    logic [IW-1:0]  lk_ovr_set = '0;
    logic [WW-1:0]  lk_ovr_way = '0;
    logic           lk_hit;
    logic [PCW-1:0] lk_target;
    logic [1:0]     lk_kind;
    logic           lk_force_taken;
    logic           upd_valid = 1'b0;
    logic [PCW-1:0] upd_pc = '0;
    logic [PCW-1:0] upd_target = '0;
    logic           upd_taken = 1'b0;
    logic [1:0]     upd_kind = '0;
    logic           upd_ovr_valid = 1'b0;
    logic [IW-1:0]  upd_ovr_set = '0;
    logic [WW-1:0]  upd_ovr_way = '0;
    logic           promo_valid;
    logic [TW-1:0]  promo_tag;
    logic [IW-1:0]  promo_set;
    logic [PCW-1:0] promo_target;

    btb_promote #(
        .NUM_SETS    (NS),
        .NUM_WAYS    (NW),
        .PC_W        (PCW),
        .MISS_THRESH (TH)
    ) dut_i (.*);

    int checks = 0;
    int errors = 0;

    // behavioural reference
    bit            mv   [NS][NW];
    logic [TW-1:0] mtag [NS][NW];
    logic [31:0]   mtgt [NS][NW];
    logic [1:0]    mkind[NS][NW];
    int            mcnt [NS][NW];
    int            ord  [NS][NW];   // position 0 = most recent way
    bit            ep_v;
    logic [TW-1:0] ep_tag;
    logic [IW-1:0] ep_set;
    logic [31:0]   ep_tgt;
    bit            promoted [NPOOL];
    int            ploc [NPOOL];
    int            pcount = 0;

    function automatic logic [31:0] pool_pc(int i);
        int s;
        case (i % 3)
            0: s = 3;
            1: s = 7;
            default: s = 12;
        endcase
        return (32'(i / 3 + 1) << (IW + 2)) | (32'(s) << 2);
    endfunction

    function automatic logic [31:0] pool_tgt(int i, int r);
        return 32'h4000_0000 + 32'(i * 256 + r * 4);
    endfunction

    function automatic void touch(int s, int w);
        int p = 0;
        for (int k = 0; k < NW; k++) if (ord[s][k] == w) p = k;
        for (int k = p; k > 0; k--) ord[s][k] = ord[s][k-1];
        ord[s][0] = w;
    endfunction

    function automatic void model_reset();
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                mv[s][w] = 1'b0;
                mcnt[s][w] = 0;
                ord[s][w] = w;
            end
        ep_v = 1'b0;
    endfunction

    task automatic step(input logic [31:0] lpc, input bit lov, input int lset, input int lway,
                        input bit uv, input logic [31:0] upc, input int pidx,
                        input logic [31:0] utgt, input bit utk, input logic [1:0] ukd,
                        input bit uov, input int uset, input int uway, input string req);
        bit e_hit;
        logic [31:0] e_tgt;
        logic [1:0] e_kind;
        bit e_ft;
        int s;
        int h;
        logic [TW-1:0] t;
        lk_pc = lpc; lk_ovr_valid = lov; lk_ovr_set = IW'(lset); lk_ovr_way = WW'(lway);
        upd_valid = uv; upd_pc = upc; upd_target = utgt; upd_taken = utk; upd_kind = ukd;
        upd_ovr_valid = uov; upd_ovr_set = IW'(uset); upd_ovr_way = WW'(uway);
        #5;
        e_hit = 1'b0; e_tgt = '0; e_kind = '0;
        if (lov) begin
            if (mv[lset][lway]) begin
                e_hit = 1'b1; e_tgt = mtgt[lset][lway]; e_kind = mkind[lset][lway];
            end
        end else begin
            s = int'(lpc[IW+1:2]);
            t = lpc[PCW-1:IW+2];
            for (int w = NW - 1; w >= 0; w--)
                if (mv[s][w] && mtag[s][w] == t) begin
                    e_hit = 1'b1; e_tgt = mtgt[s][w]; e_kind = mkind[s][w];
                end
        end
        e_ft = e_hit && e_kind == 2'd2;
        checks++;
        if (lk_hit !== e_hit || lk_target !== e_tgt || lk_kind !== e_kind || lk_force_taken !== e_ft) begin
            errors++;
            $display("FAIL %s lookup pc=%h: got hit=%0b tgt=%h kind=%0d ft=%0b, exp hit=%0b tgt=%h kind=%0d ft=%0b",
                     req, lpc, lk_hit, lk_target, lk_kind, lk_force_taken, e_hit, e_tgt, e_kind, e_ft);
        end
        checks++;
        if (promo_valid !== ep_v || (ep_v && (promo_tag !== ep_tag || promo_set !== ep_set || promo_target !== ep_tgt))) begin
            errors++;
            $display("FAIL %s promote: got v=%0b tag=%h set=%0d tgt=%h, exp v=%0b tag=%h set=%0d tgt=%h",
                     req, promo_valid, promo_tag, promo_set, promo_target, ep_v, ep_tag, ep_set, ep_tgt);
        end
        @(posedge clk);
        ep_v = 1'b0;
        if (uv) begin
            s = int'(upc[IW+1:2]);
            t = upc[PCW-1:IW+2];
            if (uov) begin
                if (utk) begin
                    mv[uset][uway] = 1'b1; mtag[uset][uway] = t; mtgt[uset][uway] = utgt;
                    mkind[uset][uway] = ukd; mcnt[uset][uway] = 0;
                end
            end else begin
                h = -1;
                for (int w = NW - 1; w >= 0; w--) if (mv[s][w] && mtag[s][w] == t) h = w;
                if (h >= 0) begin
                    touch(s, h);
                    if (utk && mtgt[s][h] != utgt) begin
                        if (mcnt[s][h] + 1 == TH) begin
                            mv[s][h] = 1'b0; mcnt[s][h] = 0;
                            ep_v = 1'b1; ep_tag = t; ep_set = IW'(s); ep_tgt = utgt;
                            if (pidx >= 0) begin
                                promoted[pidx] = 1'b1;
                                ploc[pidx] = pcount % NW;
                                pcount++;
                            end
                        end else begin
                            mtgt[s][h] = utgt; mcnt[s][h]++;
                        end
                    end
                end else if (utk) begin
                    h = ord[s][NW-1];
                    mv[s][h] = 1'b1; mtag[s][h] = t; mtgt[s][h] = utgt;
                    mkind[s][h] = ukd; mcnt[s][h] = 0;
                    touch(s, h);
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic look(input logic [31:0] lpc, input string req);
        step(lpc, 0, 0, 0, 0, '0, -1, '0, 0, 2'd0, 0, 0, 0, req);
    endtask

    task automatic resolve(input logic [31:0] lpc, input logic [31:0] upc, input int pidx,
                           input logic [31:0] tgt, input bit tk, input logic [1:0] kd, input string req);
        step(lpc, 0, 0, 0, 1, upc, pidx, tgt, tk, kd, 0, 0, 0, req);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] xpc;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        for (int i = 0; i < 4; i++) look(pool_pc(i), "R1");

        // R10: not-taken miss allocates nothing
        resolve(pool_pc(0), pool_pc(0), 0, pool_tgt(0, 0), 0, 2'd0, "R10");
        look(pool_pc(0), "R10");

        // R4 R5: fill set 3, then evict in recency order
        for (int k = 0; k < 4; k++) begin
            int i = k * 3;
            resolve(pool_pc(i), pool_pc(i), i, pool_tgt(i, 0), 1, 2'(i % 4), "R4");
            look(pool_pc(i), "R4 R2");
        end
        // R11: repeated lookups of the oldest entry must not protect it
        for (int k = 0; k < 3; k++) look(pool_pc(0), "R11");
        // R5: refresh pc 3 by a hit, then allocate a stranger
        resolve(pool_pc(3), pool_pc(3), 3, pool_tgt(3, 0), 1, 2'd3, "R5");
        xpc = (32'd9 << (IW + 2)) | (32'd3 << 2);
        resolve(xpc, xpc, -1, 32'h5555_0000, 1, 2'd1, "R5 R4");
        for (int k = 0; k < 4; k++) look(pool_pc(k * 3), "R5 R11");
        look(xpc, "R5");

        // R3: indirect entry forces taken, others do not
        resolve(pool_pc(2), pool_pc(2), 2, pool_tgt(2, 0), 1, 2'd2, "R3");
        look(pool_pc(2), "R3");
        resolve(pool_pc(1), pool_pc(1), 1, pool_tgt(1, 0), 1, 2'd1, "R3");
        look(pool_pc(1), "R3");

        // R6: not-taken hit with another target changes nothing
        resolve(pool_pc(2), pool_pc(2), 2, pool_tgt(2, 1), 0, 2'd2, "R6");
        look(pool_pc(2), "R6");

        // R6 R7: alternate targets until promotion
        for (int k = 1; k <= TH; k++) begin
            resolve(pool_pc(2), pool_pc(2), 2, pool_tgt(2, k % 2), 1, 2'd2, "R6 R7");
        end
        look(pool_pc(2), "R7");
        look(pool_pc(2), "R7");

        // R9 R8: promoted branch placed through override, never in its home set
        step(pool_pc(2), 1, OVR_SET, ploc[2], 1, pool_pc(2), 2, pool_tgt(2, 2), 1, 2'd2,
             1, OVR_SET, ploc[2], "R9");
        step(pool_pc(2), 1, OVR_SET, ploc[2], 0, '0, -1, '0, 0, 2'd0, 0, 0, 0, "R8 R9");
        look(pool_pc(2), "R9");
        step(pool_pc(2), 1, OVR_SET, 3, 0, '0, -1, '0, 0, 2'd0, 0, 0, 0, "R8");

        // mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            int i = int'($urandom % NPOOL);
            int j = int'($urandom % NPOOL);
            bit uv = ($urandom % 10) < 7;
            bit tk = ($urandom % 10) < 8;
            int r = (i % 4 == 2) ? int'($urandom % 3) : (($urandom % 8) == 0 ? 1 : 0);
            bit lov = promoted[j] || (($urandom % 8) == 0);
            int lway = promoted[j] ? ploc[j] : int'($urandom % NW);
            step(pool_pc(j), lov, OVR_SET, lway, uv, pool_pc(i), i, pool_tgt(i, r), tk, 2'(i % 4),
                 promoted[i], OVR_SET, ploc[i], "R2 R4 R5 R6 R7 R8 R9");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule